// File: doc/BRIEF.md
# SCL Low/High Divider Calculator

This block turns a functional clock rate and a requested two-wire serial clock rate into two divider values. One value sets the low phase of the serial clock and the other sets the high phase. Both rates are given in kHz. A single `start` cycle captures them. A fixed number of cycles later, `done` pulses for one cycle. In that cycle the two register-ready counts are presented, each already reduced by one, together with two flags.

The low and high phases get separate counts. Each is first sized to meet the minimum phase time of the selected speed class. If the period is still shorter than the requested rate allows, the spare divider units are handed to the low phase first. The low phase may not grow past a ceiling. That ceiling comes from the longest allowed data hold time: data is launched halfway through the low phase, so the low phase may last at most twice the hold limit minus a 50 ns safety margin. Whatever spare units the low phase does not take go to the high phase.

All five divisions run on one shared shift-subtract divider, one after another. A divider unit equals 8 functional clock cycles.

Top module: `scl_div_calc`

## Requirements
- R1: A `start` while `busy` is low captures `clk_khz` and `scl_khz`, and `busy` is high from the next cycle. A `start` while `busy` is high is ignored: the result belongs to the request already running.
- R2: `done` is high for exactly one cycle, 5*(ARITH_W+1) clock edges after the edge that accepted the request (245 by default). `busy` is low in that cycle.
- R3: A request with `scl_khz` at or below 100 uses the slow class: minimum low 4700 ns, minimum high 4000 ns, low ceiling 2*3450-50 = 6850 ns.
- R4: A request above 100 kHz uses the fast class: minimum low 1300 ns, minimum high 600 ns, low ceiling 2*900-50 = 1750 ns.
- R5: The total floor is ceil(clk/(8*scl)). The minimum low and high counts are ceil(clk*t/8000000), where t is the class minimum in ns.
- R6: The low ceiling count is floor(clk*ceiling_ns/8000000). If it is below the minimum low count, `conflict` is 1 and the ceiling is raised to the minimum low count; otherwise `conflict` is 0.
- R7: If minimum low plus minimum high is greater than the total floor, the two minimums are used unchanged.
- R8: Otherwise, spare = floor - (min low + min high). The low count is ceil(clk*min_low_ns/(8*scl*(min_low_ns+min_high_ns))), capped first by the low ceiling and then by min low + spare. The high count is min high plus the spare units the low phase left unused.
- R9: `div_low` and `div_high` are the chosen counts minus one, computed modulo 2^ARITH_W.
- R10: An output value above 2^OUT_W-1 (65535 by default) is clamped to 2^OUT_W-1.
- R11: `range_err` is 1 exactly when the request had `scl_khz` above 400. Such a request is computed with the fast class.
- R12: After reset, all outputs are 0. `div_low`, `div_high`, `conflict` and `range_err` change only in a `done` cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Request strobe |
| clk_khz | input | IN_W | Functional clock rate in kHz |
| scl_khz | input | IN_W | Requested serial clock rate in kHz |
| busy | output | 1 | Calculation in progress |
| done | output | 1 | One-cycle result strobe |
| div_low | output | OUT_W | Low-phase count minus one |
| div_high | output | OUT_W | High-phase count minus one |
| conflict | output | 1 | Low ceiling fell below the low minimum |
| range_err | output | 1 | Requested rate above 400 kHz |

## Verification
Every result is due in one cycle only: the edge 245 cycles after the edge that accepted the request. The bench counts that many edges from the accept edge. It checks that `done` is still low and `busy` still high one nanosecond after edge 244. It then checks both counts and both flags one nanosecond after edge 245, and checks one cycle later that `done` has dropped and the outputs have held. The request that arrives while busy uses the same count, taken from the first accept edge, so a wrongly accepted restart shows up as a missing or late `done` or as wrong values.

// File: rtl/scl_div_pkg.sv
package scl_div_pkg;

   // Order of the divisions run on the shared divider.
   typedef enum logic [2:0] {
      OP_TOTAL = 3'd0,
      OP_MINLO = 3'd1,
      OP_MINHI = 3'd2,
      OP_MAXLO = 3'd3,
      OP_IDEAL = 3'd4
   } div_op_e;

   typedef struct packed {
      logic [15:0] low_min_ns;
      logic [15:0] high_min_ns;
      logic [15:0] low_max_ns;
   } phase_ns_t;

   localparam int unsigned HOLD_MARGIN_NS = 50;
   // ns * kHz / 8 cycles per divider unit
   localparam int unsigned UNIT_SCALE     = 8_000_000;

   function automatic phase_ns_t phase_limits(input logic slow_class);
      phase_ns_t p;
      if (slow_class) begin
         p.low_min_ns  = 16'd4700;
         p.high_min_ns = 16'd4000;
         p.low_max_ns  = 16'(2 * 3450 - HOLD_MARGIN_NS);
      end else begin
         p.low_min_ns  = 16'd1300;
         p.high_min_ns = 16'd600;
         p.low_max_ns  = 16'(2 * 900 - HOLD_MARGIN_NS);
      end
      return p;
   endfunction

endpackage

// File: rtl/scl_div_shiftsub.sv
// Restoring shift-subtract divider, one quotient bit per cycle.
module scl_div_shiftsub #(
   parameter int unsigned W = 48
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         go,
   input  logic [W-1:0] num,
   input  logic [W-1:0] den,
   output logic         fin,
   output logic [W-1:0] quo,
   output logic [W-1:0] rem
);
   localparam int unsigned CW = $clog2(W + 1);

   logic [W-1:0]  quo_q, rem_q, den_q, diff;
   logic [W:0]    trial;
   logic [CW-1:0] cnt_q;
   logic          run_q, fin_q, take;

   assign trial = {rem_q, quo_q[W-1]};
   assign take  = (trial >= {1'b0, den_q});
   assign diff  = trial[W-1:0] - den_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         quo_q <= '0;
         rem_q <= '0;
         den_q <= '0;
         cnt_q <= '0;
         run_q <= 1'b0;
         fin_q <= 1'b0;
      end else begin
         fin_q <= 1'b0;
         if (go) begin
            quo_q <= num;
            rem_q <= '0;
            den_q <= den;
            cnt_q <= CW'(W);
            run_q <= 1'b1;
         end else if (run_q) begin
            rem_q <= take ? diff : trial[W-1:0];
            quo_q <= {quo_q[W-2:0], take};
            cnt_q <= cnt_q - 1'b1;
            if (cnt_q == CW'(1)) begin
               run_q <= 1'b0;
               fin_q <= 1'b1;
            end
         end
      end
   end

   assign fin = fin_q;
   assign quo = quo_q;
   assign rem = rem_q;
endmodule

// File: rtl/scl_div_operands.sv
// Selects dividend and divisor for each step of the sequence.
module scl_div_operands
   import scl_div_pkg::*;
#(
   parameter int unsigned IN_W        = 24,
   parameter int unsigned AW          = 48,
   parameter int unsigned STD_MAX_KHZ = 100
) (
   input  logic [2:0]      op,
   input  logic [IN_W-1:0] clk_khz,
   input  logic [IN_W-1:0] scl_khz,
   output logic [AW-1:0]   num,
   output logic [AW-1:0]   den
);
   phase_ns_t     lim;
   logic [AW-1:0] clk_w, scl8_w, t_lo, t_hi, t_max, scale;

   assign lim    = phase_limits(scl_khz <= IN_W'(STD_MAX_KHZ));
   assign clk_w  = AW'(clk_khz);
   assign scl8_w = AW'(scl_khz) << 3;
   assign t_lo   = AW'(lim.low_min_ns);
   assign t_hi   = AW'(lim.high_min_ns);
   assign t_max  = AW'(lim.low_max_ns);
   assign scale  = AW'(UNIT_SCALE);

   always_comb begin
      num = '0;
      den = {{(AW-1){1'b0}}, 1'b1};
      case (op)
         OP_TOTAL: begin num = clk_w;         den = scl8_w;                 end
         OP_MINLO: begin num = clk_w * t_lo;  den = scale;                  end
         OP_MINHI: begin num = clk_w * t_hi;  den = scale;                  end
         OP_MAXLO: begin num = clk_w * t_max; den = scale;                  end
         OP_IDEAL: begin num = clk_w * t_lo;  den = scl8_w * (t_lo + t_hi); end
         default: ;
      endcase
   end
endmodule

// File: rtl/scl_div_combine.sv
// Splits the period between low and high phase, then offsets and clamps.
module scl_div_combine #(
   parameter int unsigned AW    = 48,
   parameter int unsigned OUT_W = 16
) (
   input  logic [AW-1:0]    tot,
   input  logic [AW-1:0]    min_lo,
   input  logic [AW-1:0]    min_hi,
   input  logic [AW-1:0]    max_lo,
   input  logic [AW-1:0]    ideal_lo,
   output logic [OUT_W-1:0] lo,
   output logic [OUT_W-1:0] hi,
   output logic             conflict
);
   logic [AW-1:0] cap, hold_sum, spare, pick, lo_full, hi_full, lo_m1, hi_m1;

   always_comb begin
      conflict = (max_lo < min_lo);
      cap      = conflict ? min_lo : max_lo;
      hold_sum = min_lo + min_hi;
      spare    = '0;
      pick     = '0;
      if (hold_sum > tot) begin
         lo_full = min_lo;
         hi_full = min_hi;
      end else begin
         spare = tot - hold_sum;
         pick  = ideal_lo;
         if (pick > cap)            pick = cap;
         if (pick > min_lo + spare) pick = min_lo + spare;
         lo_full = pick;
         hi_full = min_hi + (spare - (pick - min_lo));
      end
      lo_m1 = lo_full - 1'b1;
      hi_m1 = hi_full - 1'b1;
   end

   generate
      if (OUT_W < AW) begin : g_clamp
         localparam logic [AW-1:0] OUT_MAX = AW'({OUT_W{1'b1}});
         assign lo = (lo_m1 > OUT_MAX) ? {OUT_W{1'b1}} : lo_m1[OUT_W-1:0];
         assign hi = (hi_m1 > OUT_MAX) ? {OUT_W{1'b1}} : hi_m1[OUT_W-1:0];
      end else begin : g_wide
         assign lo = OUT_W'(lo_m1);
         assign hi = OUT_W'(hi_m1);
      end
   endgenerate
endmodule

// File: rtl/scl_div_calc.sv
module scl_div_calc
   import scl_div_pkg::*;
#(
   parameter int unsigned IN_W         = 24,
   parameter int unsigned ARITH_W      = 48,
   parameter int unsigned OUT_W        = 16,
   parameter int unsigned STD_MAX_KHZ  = 100,
   parameter int unsigned FAST_MAX_KHZ = 400
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic [IN_W-1:0]  clk_khz,
   input  logic [IN_W-1:0]  scl_khz,
   output logic             busy,
   output logic             done,
   output logic [OUT_W-1:0] div_low,
   output logic [OUT_W-1:0] div_high,
   output logic             conflict,
   output logic             range_err
);
   localparam int unsigned AW = ARITH_W;

   generate
      if (IN_W + 17 > AW) begin : g_bad_arith
         $error("ARITH_W too narrow for IN_W products");
      end
      if (OUT_W > AW) begin : g_bad_out
         $error("OUT_W must not exceed ARITH_W");
      end
      if (STD_MAX_KHZ >= FAST_MAX_KHZ) begin : g_bad_class
         $error("slow class limit must lie below fast class limit");
      end
   endgenerate

   logic             busy_q, done_q, conf_q, rerr_q, accept, go, fin;
   logic [2:0]       op_q, go_op;
   logic [IN_W-1:0]  clk_q, scl_q, src_clk, src_scl;
   logic [AW-1:0]    num, den, quo, rem, rounded;
   logic [AW-1:0]    tot_q, minlo_q, minhi_q, maxlo_q;
   logic [OUT_W-1:0] lo_q, hi_q, lo_n, hi_n;
   logic             conf_n, round_up;

   assign accept   = start & ~busy_q;
   assign go_op    = accept ? OP_TOTAL : (op_q + 3'd1);
   assign go       = accept | (fin & (op_q != OP_IDEAL));
   assign src_clk  = busy_q ? clk_q : clk_khz;
   assign src_scl  = busy_q ? scl_q : scl_khz;
   assign round_up = (op_q != OP_MAXLO) && (rem != '0);
   assign rounded  = quo + {{(AW-1){1'b0}}, round_up};

   scl_div_operands #(.IN_W(IN_W), .AW(AW), .STD_MAX_KHZ(STD_MAX_KHZ)) u_ops (
      .op      (go_op),
      .clk_khz (src_clk),
      .scl_khz (src_scl),
      .num     (num),
      .den     (den)
   );

   scl_div_shiftsub #(.W(AW)) u_div (
      .clk   (clk),
      .rst_n (rst_n),
      .go    (go),
      .num   (num),
      .den   (den),
      .fin   (fin),
      .quo   (quo),
      .rem   (rem)
   );

   scl_div_combine #(.AW(AW), .OUT_W(OUT_W)) u_mix (
      .tot      (tot_q),
      .min_lo   (minlo_q),
      .min_hi   (minhi_q),
      .max_lo   (maxlo_q),
      .ideal_lo (rounded),
      .lo       (lo_n),
      .hi       (hi_n),
      .conflict (conf_n)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_q  <= 1'b0;
         done_q  <= 1'b0;
         op_q    <= OP_TOTAL;
         clk_q   <= '0;
         scl_q   <= '0;
         tot_q   <= '0;
         minlo_q <= '0;
         minhi_q <= '0;
         maxlo_q <= '0;
         lo_q    <= '0;
         hi_q    <= '0;
         conf_q  <= 1'b0;
         rerr_q  <= 1'b0;
      end else begin
         done_q <= 1'b0;
         if (accept) begin
            busy_q <= 1'b1;
            op_q   <= OP_TOTAL;
            clk_q  <= clk_khz;
            scl_q  <= scl_khz;
         end else if (fin) begin
            case (op_q)
               OP_TOTAL: tot_q   <= rounded;
               OP_MINLO: minlo_q <= rounded;
               OP_MINHI: minhi_q <= rounded;
               OP_MAXLO: maxlo_q <= rounded;
               default: ;
            endcase
            if (op_q == OP_IDEAL) begin
               busy_q <= 1'b0;
               done_q <= 1'b1;
               lo_q   <= lo_n;
               hi_q   <= hi_n;
               conf_q <= conf_n;
               rerr_q <= (scl_q > IN_W'(FAST_MAX_KHZ));
            end else begin
               op_q <= op_q + 3'd1;
            end
         end
      end
   end

   assign busy      = busy_q;
   assign done      = done_q;
   assign div_low   = lo_q;
   assign div_high  = hi_q;
   assign conflict  = conf_q;
   assign range_err = rerr_q;
endmodule

// File: rtl/scl_div_calc_chk.sv
module scl_div_calc_chk #(
   parameter int unsigned IN_W         = 24,
   parameter int unsigned ARITH_W      = 48,
   parameter int unsigned OUT_W        = 16,
   parameter int unsigned FAST_MAX_KHZ = 400
) (
   input logic             clk,
   input logic             rst_n,
   input logic             start,
   input logic [IN_W-1:0]  scl_khz,
   input logic             busy,
   input logic             done,
   input logic [OUT_W-1:0] div_low,
   input logic [OUT_W-1:0] div_high,
   input logic             conflict,
   input logic             range_err
);
   localparam int unsigned LAT = 5 * (ARITH_W + 1);
   localparam int unsigned CW  = $clog2(LAT + 1) + 1;

   logic [CW-1:0]   since_q;
   logic [IN_W-1:0] scl_cap;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         since_q <= '0;
         scl_cap <= '0;
      end else if (start && !busy) begin
         since_q <= '0;
         scl_cap <= scl_khz;
      end else if (busy) begin
         since_q <= since_q + 1'b1;
      end
   end

   assert_accept_busy_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (start && !busy) |=> busy);
   assert_no_restart_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (start && busy) |=> (busy || done));
   assert_done_latency_R2: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (since_q == CW'(LAT)));
   assert_done_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);
   assert_done_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !busy);
   assert_range_flag_R11: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (range_err == (scl_cap > IN_W'(FAST_MAX_KHZ))));
   assert_hold_divs_R12: assert property (@(posedge clk) disable iff (!rst_n)
      !done |-> ($stable(div_low) && $stable(div_high)));
   assert_hold_flags_R12: assert property (@(posedge clk) disable iff (!rst_n)
      !done |-> ($stable(conflict) && $stable(range_err)));
endmodule

bind scl_div_calc scl_div_calc_chk #(
   .IN_W         (IN_W),
   .ARITH_W      (ARITH_W),
   .OUT_W        (OUT_W),
   .FAST_MAX_KHZ (FAST_MAX_KHZ)
) u_chk (.*);

// File: tb/scl_div_calc_tb.sv
module scl_div_calc_tb;
   localparam int unsigned IN_W = 24;
   localparam int unsigned AW   = 48;
   localparam int unsigned OW   = 16;
   localparam int unsigned LAT  = 5 * (AW + 1);

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          start = 1'b0;
   logic [IN_W-1:0] clk_khz = '0, scl_khz = '0;
   logic          busy, done, conflict, range_err;
   logic [OW-1:0] div_low, div_high;

   int unsigned checks = 0, fails = 0, cycles = 0;

   always #5 clk = ~clk;

   scl_div_calc u_dut (
      .clk(clk), .rst_n(rst_n), .start(start), .clk_khz(clk_khz), .scl_khz(scl_khz),
      .busy(busy), .done(done), .div_low(div_low), .div_high(div_high),
      .conflict(conflict), .range_err(range_err)
   );

   task automatic summary();
      $display("%0d/%0d checks passed", checks - fails, checks);
   endtask

   always @(posedge clk) begin
      cycles++;
      if (cycles == 150000) begin
         checks++; fails++;
         $display("FAIL watchdog: actual=%0d expected<%0d cycles", cycles, 150000);
         summary();
         $finish;
      end
   end

   task automatic chk(input bit ok, input string req, input longint act, input longint exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   // Expected results computed from the requirement arithmetic.
   task automatic model(input int unsigned ck, input int unsigned sc,
                        output logic [OW-1:0] e_lo, output logic [OW-1:0] e_hi,
                        output bit e_cf, output bit e_re, output string tag);
      logic [AW-1:0] c, s8, tl, th, tm, tot, ml, mh, mx, id, cap, ex, pk, lf, hf, l1, h1;
      bit slow;
      c = AW'(ck); s8 = AW'(sc) * 48'd8;
      slow = (sc <= 100);
      tl = slow ? 48'd4700 : 48'd1300;
      th = slow ? 48'd4000 : 48'd600;
      tm = slow ? 48'd6850 : 48'd1750;
      tag = slow ? "R3" : "R4";
      tot = (c + s8 - 48'd1) / s8;
      ml  = (c * tl + 48'd7999999) / 48'd8000000;
      mh  = (c * th + 48'd7999999) / 48'd8000000;
      mx  = (c * tm) / 48'd8000000;
      id  = (c * tl + s8 * (tl + th) - 48'd1) / (s8 * (tl + th));
      e_cf = (mx < ml);
      cap = e_cf ? ml : mx;
      if (ml + mh > tot) begin
         lf = ml; hf = mh; tag = {tag, "/R7"};
      end else begin
         ex = tot - (ml + mh);
         pk = (id < cap) ? id : cap;
         if (pk > ml + ex) pk = ml + ex;
         lf = pk; hf = mh + ex - (pk - ml);
         tag = {tag, "/R8"};
      end
      l1 = lf - 48'd1; h1 = hf - 48'd1;
      if (l1 > 48'd65535 || h1 > 48'd65535) tag = {tag, "/R10"};
      e_lo = (l1 > 48'd65535) ? 16'hFFFF : l1[OW-1:0];
      e_hi = (h1 > 48'd65535) ? 16'hFFFF : h1[OW-1:0];
      e_re = (sc > 400);
      tag = {tag, "/R5/R9"};
   endtask

   task automatic issue(input int unsigned ck, input int unsigned sc);
      @(negedge clk);
      clk_khz = IN_W'(ck); scl_khz = IN_W'(sc); start = 1'b1;
      @(negedge clk);
      start = 1'b0;
   endtask

   // spent: edges already passed after the accept edge
   task automatic await_and_check(input int unsigned ck, input int unsigned sc, input int unsigned spent);
      logic [OW-1:0] e_lo, e_hi, h_lo, h_hi;
      bit e_cf, e_re;
      string tag;
      model(ck, sc, e_lo, e_hi, e_cf, e_re, tag);
      repeat (LAT - 1 - spent) @(posedge clk);
      #1;
      chk(!done && busy, "R2 done early or busy dropped", {done, busy}, 2'b01);
      @(posedge clk);
      #1;
      chk(done && !busy, "R2 done missing at latency", {done, busy}, 2'b10);
      chk(div_low == e_lo, {tag, " div_low"}, div_low, e_lo);
      chk(div_high == e_hi, {tag, " div_high"}, div_high, e_hi);
      chk(conflict == e_cf, "R6 conflict", conflict, e_cf);
      chk(range_err == e_re, "R11 range_err", range_err, e_re);
      h_lo = div_low; h_hi = div_high;
      @(posedge clk);
      #1;
      chk(!done && div_low == h_lo && div_high == h_hi, "R12 done pulse / hold",
          {done, div_low, div_high}, {1'b0, h_lo, h_hi});
   endtask

   int unsigned clk_set[10] = '{1000, 12000, 24000, 50000, 74250, 100000, 133333, 200000, 1000000, 16000000};
   int unsigned scl_set[11] = '{1, 10, 47, 99, 100, 101, 250, 399, 400, 401, 1000};

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      #1;
      chk(!busy && !done && div_low == 0 && div_high == 0 && !conflict && !range_err,
          "R12 reset state", {busy, done, div_low, div_high, conflict, range_err}, 0);

      // R1: restart while busy must not disturb the running request
      issue(100000, 400);
      repeat (2) @(negedge clk);
      clk_khz = IN_W'(24000); scl_khz = IN_W'(10); start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      await_and_check(100000, 400, 3);

      // Sweep over rate pairs: R3 R4 R5 R6 R7 R8 R9 R10 R11
      foreach (clk_set[i]) begin
         foreach (scl_set[j]) begin
            issue(clk_set[i], scl_set[j]);
            await_and_check(clk_set[i], scl_set[j], 0);
         end
      end

      summary();
      $finish;
   end
endmodule